// File: doc/BRIEF.md
# Asynchronous serial byte receiver

This block turns a single asynchronous serial line into bytes. Each frame on the line has one low start bit, eight data bits with the least significant bit first, no parity bit and one high stop bit, which makes ten bit periods in all. The block resynchronizes the line to its clock and waits for the line to go low. It then samples the whole ten-bit frame near the middle of each bit period. It copies the eight data bits into an output register and raises a strobe for one clock cycle.

A consumer captures `rx_byte` in any cycle where `rx_strobe` is high. The output register keeps the byte until the next frame is loaded. The bit period, in clock cycles, is the clock frequency divided by the baud rate. The default is a 12 MHz clock at 115200 baud. The supported rates run from 300 to 115200 baud. A bench or a faster chip can override the divisor directly.

Top module: `serial_byte_rx`

## Requirements
- R1: Each frame is decoded with the first data bit after the start bit as bit 0 of `rx_byte`, and the following bits fill bits 1 to 7 in order.
- R2: `rx_strobe` goes high exactly once for each received frame and stays high for exactly one clock cycle.
- R3: `rx_byte` holds the received byte while `rx_strobe` is high and does not change until the next frame is loaded.
- R4: While `rst_n` is low at a clock edge, the block returns to idle, `rx_strobe` is low and `rx_byte` is 0x00.
- R5: One bit period lasts `DIV` clock cycles, with `DIV` defaulting to `CLK_HZ / BAUD`. Frames sent at that period are received correctly.
- R6: The stop bit is not checked. A frame whose stop bit is low still loads its data and pulses `rx_strobe`.
- R7: Frames sent back to back with no idle time between them are all received.
- R8: If the line is still low when the block returns to idle after a strobe, that low level starts a new frame at once. A line held low for nine further bit periods after a low stop bit, then released high, yields the byte 0x00.
- R9: A reset in the middle of a frame discards the partial frame, so no strobe follows it. The next complete frame is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_in | input | 1 | Asynchronous serial line, idles high |
| rx_byte | output | 8 | Last received byte |
| rx_strobe | output | 1 | One-cycle pulse when a new byte is in `rx_byte` |

## Verification
Two functions can fall in the same cycle: the end of one frame (load, strobe, return to idle) and the start of the next frame, when the line is already low. The bench provokes this in two ways. It sends frames with no gap between them. It also sends a frame with a low stop bit and then holds the line low, so the idle state sees a start condition in its first cycle. The scoreboard judges both cases by the bytes that come out. The gapless frames must arrive intact and in order. The held-low line must produce one extra 0x00 byte and nothing else.

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
  parameter int CLK_HZ    = 12_000_000,
  parameter int BAUD      = 115_200,
  parameter int DIV       = CLK_HZ / BAUD,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_in,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_strobe
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int HALF       = DIV / 2;
  localparam int CW         = $clog2(DIV);
  localparam int BW         = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_LOAD, ST_AVAIL} st_t;
  st_t st;

  logic [1:0] sync;
  wire line = sync[1];

  always_ff @(posedge clk)
    sync <= !rst_n ? 2'b11 : {sync[0], rx_in};

  logic [CW-1:0] bcnt;
  wire baud_on = (st == ST_RECV);
  wire tick    = baud_on && (bcnt == '0);

  always_ff @(posedge clk)
    if (!rst_n || !baud_on) bcnt <= CW'(HALF);
    else if (tick)          bcnt <= CW'(DIV - 1);
    else                    bcnt <= bcnt - 1'b1;

  logic [BW-1:0] nbits;
  always_ff @(posedge clk)
    if (!rst_n || st == ST_IDLE) nbits <= '0;
    else if (tick)               nbits <= nbits + 1'b1;

  logic [FRAME_BITS-1:0] frame;
  always_ff @(posedge clk)
    if (!rst_n)    frame <= '1;
    else if (tick) frame <= {line, frame[FRAME_BITS-1:1]};

  always_ff @(posedge clk)
    if (!rst_n) st <= ST_IDLE;
    else
      case (st)
        ST_IDLE:  if (!line) st <= ST_RECV;
        ST_RECV:  if (nbits == BW'(FRAME_BITS)) st <= ST_LOAD;
        ST_LOAD:  st <= ST_AVAIL;
        default:  st <= ST_IDLE;
      endcase

  always_ff @(posedge clk)
    if (!rst_n)            rx_byte <= '0;
    else if (st == ST_LOAD) rx_byte <= frame[FRAME_BITS-2:1];

  assign rx_strobe = (st == ST_AVAIL);

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);

  p_strobe_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> $past(st == ST_LOAD));

  p_byte_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_LOAD) |=> $stable(rx_byte));

  p_idle_clears_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> (nbits == '0));

  p_count_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    nbits <= BW'(FRAME_BITS));

  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: tb/tb_serial_byte_rx.sv
`timescale 1ns/1ps
module tb_serial_byte_rx;
  localparam int DIV = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic rx_in = 1;
  logic [7:0] rx_byte;
  logic rx_strobe;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_byte = 8'h00;
  logic prev_strobe = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_byte_rx #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
    .rx_byte(rx_byte), .rx_strobe(rx_strobe)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold_bit(input logic v);
    rx_in = v;
    repeat (DIV) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input bit expect_it);
    if (expect_it) exp_q.push_back(b);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(b[i]);
    hold_bit(stop);
  endtask

  task automatic idle_bits(input int n);
    rx_in = 1;
    repeat (n * DIV) @(posedge clk);
    #1;
  endtask

  // Monitor: pops the scoreboard on each strobe, checks the width of the strobe
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_strobe && prev_strobe)
        check(0, "R2 strobe longer than one cycle", 8'h1, 8'h0);
      if (rx_strobe && !prev_strobe) begin
        if (exp_q.size() == 0)
          check(0, "R2/R9 unexpected strobe", rx_byte, 8'h00);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rx_byte == e, "R1/R5 byte mismatch", rx_byte, e);
          last_byte = e;
        end
      end
      prev_strobe = rx_strobe;
    end else
      prev_strobe = 0;
  end

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%02h expected=%02h", 8'h1, 8'h0);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(rx_strobe == 0, "R4 strobe low in reset", {7'b0, rx_strobe}, 8'h00);
    check(rx_byte == 8'h00, "R4 byte cleared in reset", rx_byte, 8'h00);
    @(posedge clk); #1;
    rst_n = 1;
    idle_bits(2);

    // R1 R5: two characters at the reduced divisor
    send_frame(8'h55, 1, 1);
    idle_bits(2);
    send_frame(8'h4B, 1, 1);
    idle_bits(3);
    check(exp_q.size() == 0, "R2 missing strobe", 8'(exp_q.size()), 8'h00);
    @(negedge clk);
    check(rx_byte == 8'h4B, "R3 byte held after strobe", rx_byte, 8'h4B);
    idle_bits(4);
    check(rx_byte == 8'h4B, "R3 byte still held while idle", rx_byte, 8'h4B);

    // R7: back-to-back frames without idle time
    send_frame(8'hA5, 1, 1);
    send_frame(8'h0F, 1, 1);
    send_frame(8'hFF, 1, 1);
    send_frame(8'h00, 1, 1);
    send_frame(8'h81, 1, 1);
    idle_bits(3);
    check(exp_q.size() == 0, "R7 back-to-back frames lost", 8'(exp_q.size()), 8'h00);

    // R6 R8: low stop bit, line kept low, restarts immediately into 0x00
    send_frame(8'h3C, 0, 1);
    exp_q.push_back(8'h00);
    rx_in = 0;
    repeat (9 * DIV) @(posedge clk);
    #1;
    idle_bits(4);
    check(exp_q.size() == 0, "R6/R8 low stop handling", 8'(exp_q.size()), 8'h00);
    @(negedge clk);
    check(rx_byte == 8'h00, "R8 restarted frame byte", rx_byte, 8'h00);

    // R9: reset in the middle of a frame
    send_frame(8'h7E, 1, 1);
    idle_bits(2);
    hold_bit(1'b0);
    hold_bit(1'b1);
    hold_bit(1'b0);
    rx_in = 1;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rx_byte == 8'h00, "R4/R9 byte cleared by mid-frame reset", rx_byte, 8'h00);
    check(rx_strobe == 0, "R9 strobe low in reset", {7'b0, rx_strobe}, 8'h00);
    @(posedge clk); #1;
    rst_n = 1;
    idle_bits(12);
    check(rx_byte == 8'h00, "R9 no load after aborted frame", rx_byte, 8'h00);
    send_frame(8'hC3, 1, 1);
    idle_bits(3);
    check(exp_q.size() == 0, "R9 frame after reset", 8'(exp_q.size()), 8'h00);
    @(negedge clk);
    check(rx_byte == 8'hC3, "R9 byte after reset", rx_byte, 8'hC3);

    finish_run();
  end
endmodule